// File: doc/BRIEF.md
# Edge-Triggered Interrupt Flag Collector

This block gathers five interrupt sources into one 8-bit pending-flag register: two single-cycle overflow strobes from internal timers and three external pins. Each pin is first resynchronized through a two-flop chain. An edge detector then watches it for the edge that pin's rule calls for. Every detected event sets a sticky flag at a fixed bit position, and the flag stays set until software clears it.

An 8-bit enable register is combined with the flags. Any enabled pending flag among the implemented bits raises a single registered request line toward the processor. When a pin is assigned to an alternate function, its source is switched off completely: its flag can no longer be set, it reads as 0 and it cannot raise the request.

Both registers sit on a plain single-cycle register port with an address, write enable, write data and combinational read data. No streaming data passes through the block, so no valid/ready handshake exists and every pin is plain control or status.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset, the flag register, the enable register and `irq_req` are all 0.
- R2: A 1-cycle pulse on `tmr0_ovf` sets flag bit 0. A pulse on `tmr1_ovf` sets flag bit 1.
- R3: Pin 0 sets flag bit 3 on a rising edge when `pin0_pol` is 1, and on a falling edge when `pin0_pol` is 0. The edge of the other direction does nothing.
- R4: Pin 1 sets flag bit 4 only on a falling edge. Pin 3 sets flag bit 7 only on a falling edge.
- R5: A pin edge first shows in the flag register 3 clock edges after the changed pin value is sampled: 2 synchronizer flops and 1 flag flop.
- R6: Flags are sticky. Writing address 0 (flags) clears each bit written as 0 and leaves each bit written as 1 unchanged.
- R7: When a hardware set and a software clear hit the same bit in the same cycle, the bit ends up set.
- R8: Flag bits 2, 5 and 6 always read 0, and writes to them have no effect.
- R9: Address 1 holds the enable register. It is fully readable and writable.
- R10: `irq_req` equals the registered OR of (flag AND enable) over bits 0, 1, 3, 4 and 7. It is high in the cycle after a qualifying flag/enable state.
- R11: When `pin0_alt`=1, flag bit 3 reads 0, cannot be set and does not drive `irq_req`. When `pin1_alt`=1, the same holds for flag bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 1 | 0 = flag register, 1 = enable register |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| tmr0_ovf | input | 1 | Main timer overflow strobe |
| tmr1_ovf | input | 1 | Counter 1 overflow strobe |
| pin0_in | input | 1 | External pin 0 (asynchronous) |
| pin1_in | input | 1 | External pin 1 (asynchronous) |
| pin3_in | input | 1 | External pin 3 (asynchronous) |
| pin0_pol | input | 1 | Pin 0 edge select: 1 = rising, 0 = falling |
| pin0_alt | input | 1 | Pin 0 assigned to its alternate function |
| pin1_alt | input | 1 | Pin 1 assigned to its alternate function |
| irq_req | output | 1 | Registered interrupt request |

## Verification
The assertions watch several properties on every cycle:
- the unused flag bits stay at zero;
- the flags are sticky when no clearing write occurs;
- a hardware set beats a software clear;
- a source assigned to its alternate function stays silent;
- the request line follows the masked flags one cycle later.

Only the bench scenarios can show the rest. These are the edge rules per pin, including the polarity switch, the exact three-edge latency from the pin to the flag, and that opposite edges are ignored.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;
  localparam int REG_W = 8;
  localparam int BIT_T0 = 0;
  localparam int BIT_T1 = 1;
  localparam int BIT_P0 = 3;
  localparam int BIT_P1 = 4;
  localparam int BIT_P3 = 7;
  localparam logic [REG_W-1:0] IMPL_MASK = 8'b1001_1011;
  typedef enum logic {ADDR_FLAG = 1'b0, ADDR_MASK = 1'b1} reg_sel_e;
  typedef enum logic [1:0] {EDGE_RISE = 2'd0, EDGE_FALL = 2'd1, EDGE_SEL = 2'd2} edge_mode_e;
endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic d_out
);
  logic [STAGES-1:0] chain;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else chain <= {chain[STAGES-2:0], d_in};
  end
  assign d_out = chain[STAGES-1];
endmodule

// File: rtl/irq_edge_det.sv
module irq_edge_det
  import irq_flag_pkg::*;
#(
  parameter edge_mode_e MODE = EDGE_FALL
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic pol_rise,
  output logic hit
);
  logic prev;
  logic rise, fall;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else prev <= lvl;
  end
  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;
  generate
    if (MODE == EDGE_RISE) begin : g_rise
      assign hit = rise;
    end else if (MODE == EDGE_FALL) begin : g_fall
      assign hit = fall;
    end else begin : g_sel
      assign hit = pol_rise ? rise : fall;
    end
  endgenerate
endmodule

// File: rtl/irq_flag_regs.sv
module irq_flag_regs
  import irq_flag_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] set_vec,
  input  logic [REG_W-1:0] live_vec,
  input  logic             reg_addr,
  input  logic             reg_we,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] flags,
  output logic [REG_W-1:0] mask,
  output logic             irq_req
);
  logic [REG_W-1:0] flag_q, flag_d, keep;
  logic flag_wr, mask_wr;
  assign flag_wr = reg_we && (reg_addr == ADDR_FLAG);
  assign mask_wr = reg_we && (reg_addr == ADDR_MASK);
  assign keep = flag_wr ? reg_wdata : '1;
  assign flag_d = ((flag_q & keep) | set_vec) & live_vec;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= '0;
      mask    <= '0;
      irq_req <= 1'b0;
    end else begin
      flag_q <= flag_d;
      if (mask_wr) mask <= reg_wdata;
      irq_req <= |(flag_q & mask & live_vec);
    end
  end
  assign flags = flag_q & live_vec;
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
  import irq_flag_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_addr,
  input  logic       reg_we,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       tmr0_ovf,
  input  logic       tmr1_ovf,
  input  logic       pin0_in,
  input  logic       pin1_in,
  input  logic       pin3_in,
  input  logic       pin0_pol,
  input  logic       pin0_alt,
  input  logic       pin1_alt,
  output logic       irq_req
);
  localparam int NPIN = 3;
  localparam int PIN_BIT [NPIN] = '{BIT_P0, BIT_P1, BIT_P3};
  logic [NPIN-1:0] pin_raw, pin_s, pin_hit;
  logic [REG_W-1:0] set_vec, live_vec, flags, mask;

  assign pin_raw = {pin3_in, pin1_in, pin0_in};

  generate
    for (genvar i = 0; i < NPIN; i++) begin : g_pin
      irq_pin_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_in(pin_raw[i]), .d_out(pin_s[i]));
      irq_edge_det #(.MODE(i == 0 ? EDGE_SEL : EDGE_FALL)) u_edge (
        .clk(clk), .rst_n(rst_n), .lvl(pin_s[i]), .pol_rise(pin0_pol),
        .hit(pin_hit[i]));
    end
  endgenerate

  always_comb begin
    set_vec = '0;
    set_vec[BIT_T0] = tmr0_ovf;
    set_vec[BIT_T1] = tmr1_ovf;
    for (int i = 0; i < NPIN; i++) set_vec[PIN_BIT[i]] = pin_hit[i];
    live_vec = IMPL_MASK;
    if (pin0_alt) live_vec[BIT_P0] = 1'b0;
    if (pin1_alt) live_vec[BIT_P1] = 1'b0;
  end

  irq_flag_regs u_regs (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .live_vec(live_vec),
    .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .flags(flags), .mask(mask), .irq_req(irq_req));

  assign reg_rdata = (reg_addr == ADDR_MASK) ? mask : flags;
endmodule

// File: rtl/irq_flag_ctrl_chk.sv
module irq_flag_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_addr,
  input logic       reg_we,
  input logic [7:0] reg_wdata,
  input logic       tmr0_ovf,
  input logic       tmr1_ovf,
  input logic       pin0_alt,
  input logic       pin1_alt,
  input logic [7:0] flags,
  input logic [7:0] mask,
  input logic       irq_req
);
  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[2] | flags[5] | flags[6]) == 1'b0); // R8
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!(reg_we && !reg_addr) && !pin0_alt && !pin1_alt) |=> ((flags & $past(flags)) == $past(flags))); // R6
  AST_SET_WINS_T0: assert property (@(posedge clk) disable iff (!rst_n)
    tmr0_ovf |=> flags[0]); // R7
  AST_SET_WINS_T1: assert property (@(posedge clk) disable iff (!rst_n)
    tmr1_ovf |=> flags[1]); // R2
  AST_ALT0_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    pin0_alt |-> !flags[3]); // R11
  AST_ALT1_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    pin1_alt |-> !flags[4]); // R11
  AST_REQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $stable(pin0_alt) && $stable(pin1_alt)) |-> (irq_req == |($past(flags) & $past(mask)))); // R10
endmodule

bind irq_flag_ctrl irq_flag_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
  .reg_wdata(reg_wdata), .tmr0_ovf(tmr0_ovf), .tmr1_ovf(tmr1_ovf),
  .pin0_alt(pin0_alt), .pin1_alt(pin1_alt), .flags(flags), .mask(mask),
  .irq_req(irq_req));

// File: tb/tb_irq_flag_ctrl.sv
module tb_irq_flag_ctrl;
  logic clk = 0, rst_n = 0;
  logic reg_addr = 0, reg_we = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic tmr0_ovf = 0, tmr1_ovf = 0;
  logic pin0_in = 0, pin1_in = 1, pin3_in = 1;
  logic pin0_pol = 1, pin0_alt = 0, pin1_alt = 0;
  logic irq_req;
  int n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  irq_flag_ctrl dut (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    reg_addr = a; reg_we = 0; #0.5; v = reg_rdata;
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    reg_addr = a; reg_we = 1; reg_wdata = d; tick(); reg_we = 0;
  endtask

  // vector: which pin (0,1,3), pol, start level, end level, expected flag
  typedef struct packed { logic [1:0] pin; logic pol; logic lvl0; logic lvl1; logic [7:0] expf; } vec_t;
  localparam vec_t VT [8] = '{
    '{2'd0, 1'b1, 1'b0, 1'b1, 8'h08}, // R3 rising, rising selected
    '{2'd0, 1'b1, 1'b1, 1'b0, 8'h00}, // R3 falling ignored
    '{2'd0, 1'b0, 1'b1, 1'b0, 8'h08}, // R3 falling selected
    '{2'd0, 1'b0, 1'b0, 1'b1, 8'h00}, // R3 rising ignored
    '{2'd1, 1'b0, 1'b1, 1'b0, 8'h10}, // R4 pin1 falling
    '{2'd1, 1'b0, 1'b0, 1'b1, 8'h00}, // R4 pin1 rising ignored
    '{2'd3, 1'b0, 1'b1, 1'b0, 8'h80}, // R4 pin3 falling
    '{2'd3, 1'b0, 1'b0, 1'b1, 8'h00}  // R4 pin3 rising ignored
  };

  task automatic setpin(input logic [1:0] p, input logic v);
    case (p) 2'd0: pin0_in = v; 2'd1: pin1_in = v; default: pin3_in = v; endcase
  endtask

  initial begin
    #40000;
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    tick(2); rst_n = 1; tick();
    rd(0, v); chk("R1 flags", v, 8'h00);
    rd(1, v); chk("R1 mask", v, 8'h00);
    chk("R1 irq", {7'b0, irq_req}, 8'h00);

    for (int i = 0; i < 8; i++) begin
      pin0_pol = VT[i].pol;
      setpin(VT[i].pin, VT[i].lvl0);
      tick(5);
      wr(0, 8'h00);
      setpin(VT[i].pin, VT[i].lvl1);
      tick(5);
      rd(0, v); chk($sformatf("R3/R4 vector %0d", i), v, VT[i].expf);
      setpin(VT[i].pin, VT[i].pin == 2'd0 ? 1'b0 : 1'b1);
      tick(5); wr(0, 8'h00);
    end

    // R5 latency: pin changes before edge k; flag visible after edge k+2
    pin0_pol = 1; pin0_in = 0; tick(5); wr(0, 0);
    pin0_in = 1; tick(2);
    rd(0, v); chk("R5 not yet after 2 edges", v, 8'h00);
    tick(1);
    rd(0, v); chk("R5 set after 3 edges", v, 8'h08);
    pin0_in = 0; tick(5); wr(0, 0);

    // R2 timers
    tmr0_ovf = 1; tick(); tmr0_ovf = 0;
    rd(0, v); chk("R2 timer0", v, 8'h01);
    tmr1_ovf = 1; tick(); tmr1_ovf = 0;
    rd(0, v); chk("R2 timer1", v, 8'h03);
    tick(3);
    rd(0, v); chk("R6 sticky", v, 8'h03);
    wr(0, 8'hFE);
    rd(0, v); chk("R6 write-0 clears only bit0", v, 8'h02);

    // R7 set wins
    reg_addr = 0; reg_we = 1; reg_wdata = 8'h00; tmr0_ovf = 1; tick();
    reg_we = 0; tmr0_ovf = 0;
    rd(0, v); chk("R7 set beats clear", v, 8'h01);
    wr(0, 0);

    // R8 unused bits
    wr(0, 8'hFF);
    rd(0, v); chk("R8 unused read 0", v, 8'h00);

    // R9 mask
    wr(1, 8'hA5); rd(1, v); chk("R9 mask rw", v, 8'hA5);
    wr(1, 8'h00); rd(1, v); chk("R9 mask clear", v, 8'h00);

    // R10 request
    tmr1_ovf = 1; tick(); tmr1_ovf = 0; tick();
    chk("R10 masked off", {7'b0, irq_req}, 8'h00);
    wr(1, 8'h02);
    chk("R10 mask just set, not yet", {7'b0, irq_req}, 8'h00);
    tick();
    chk("R10 request high", {7'b0, irq_req}, 8'h01);
    wr(0, 8'h00); tick();
    chk("R10 request drops", {7'b0, irq_req}, 8'h00);

    // R11 alternate function
    wr(1, 8'hFF);
    pin0_alt = 1; pin0_pol = 1; pin0_in = 1; tick(5);
    rd(0, v); chk("R11 pin0 alt flag", v, 8'h00);
    chk("R11 pin0 alt irq", {7'b0, irq_req}, 8'h00);
    pin1_alt = 1; pin1_in = 0; tick(5);
    rd(0, v); chk("R11 pin1 alt flag", v, 8'h00);
    pin1_alt = 0; pin1_in = 1; tick(5);
    pin1_in = 0; tick(5);
    rd(0, v); chk("R11 pin1 restored", v, 8'h10);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule